// File: doc/BRIEF.md
# Page-Buffered Program Sequencer

This block is the program-control core of a byte-wide nonvolatile memory that is written one whole page at a time. Callers present qualified byte-load events, each with an address and a data byte. The block gathers them into a 64-byte page latch, and the bytes may arrive in any order. A load window stays open while loads keep arriving. Once a programmable number of clock cycles passes without a new load, the window closes. The block then runs an internal timed cycle that first erases the target page of a small on-chip storage array and then writes the latched bytes into it.

While that cycle runs, the block raises `busy`. It ignores any further byte loads and holds its address and data latches, so the external bus is free for other use. A read during the busy period does not return array contents. It returns a status byte built from the last byte loaded: the top bit is inverted, and bit 6 flips on every successive read. Software can poll either bit to detect the end of the cycle. After completion, reads return true array contents again. Both timing values are counted in clock cycles: `WIN_CYC` sets the idle window and `CYC_CYC` sets the busy period.

Top module: `page_prog_seq`

## Requirements
- R1: After reset `busy` is 0 and every storage byte reads as 0xFF.
- R2: A load writes `ld_data` into the page-latch byte selected by `ld_addr[5:0]`. Bytes may be loaded in any order, and after the program cycle each loaded byte reads back at its address.
- R3: A load accepted on edge E reopens the window. A further load on any of edges E+1 to E+WIN_CYC is accepted. If none arrives, `busy` rises on edge E+WIN_CYC.
- R4: `busy` stays high for exactly CYC_CYC clock cycles and then falls.
- R5: The program cycle erases the whole target page before writing it. Any byte of that page not loaded in the window reads 0xFF afterwards, whatever it held before.
- R6: A read taken while busy returns the last loaded byte with bit 7 inverted and bits 5:0 unchanged.
- R7: Bit 6 of a busy read is 0 on the first read of a cycle and flips on each further busy read.
- R8: Byte loads presented while busy are ignored. They affect neither the page being programmed nor the next cycle.
- R9: The page written is selected by `ld_addr[14:6]` of the last accepted load. The array holds STORE_PAGES pages, selected by the low bits of the page number.
- R10: `rd_data` updates one cycle after `rd_en` and holds its value while `rd_en` is low.
- R11: Pages other than the target page are unchanged by a program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Qualified byte-load event |
| ld_addr | input | ADDR_W | Load address: page number above, byte offset in the low 6 bits |
| ld_data | input | DATA_W | Load data byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data or busy status |
| busy | output | 1 | Program cycle in progress |

## Verification
On every cycle, the assertions check the following:
- `busy` is continuous until its final cycle and then drops.
- `busy` never rises on an edge that accepted a load.
- The load mask and the captured page number do not move while busy.
- A busy read always carries an inverted top bit.
- `rd_data` is stable when no read is requested.

The bench scenarios show the rest:
- the exact window length and its extension by a late load;
- the exact busy length;
- the toggle sequence across several polls;
- erasure of unloaded bytes and untouched neighbouring pages;
- loads during busy leaving no trace in the array.

// File: rtl/ppseq_pkg.sv
package ppseq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_ERASE  = 2'd1,
      PH_PROG   = 2'd2,
      PH_SETTLE = 2'd3
   } ppseq_phase_e;
endpackage

// File: rtl/ppseq_load_window.sv
module ppseq_load_window #(
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 8,
   parameter int OFF_W   = 6,
   parameter int WIN_CYC = 7500
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   ld_valid_i,
   input  logic [ADDR_W-1:0]                      ld_addr_i,
   input  logic [DATA_W-1:0]                      ld_data_i,
   input  logic                                   busy_i,
   input  logic                                   clear_i,
   output logic                                   start_o,
   output logic [ADDR_W-OFF_W-1:0]                page_o,
   output logic [DATA_W-1:0]                      last_data_o,
   output logic [(1<<OFF_W)-1:0]                  mask_o,
   output logic [(1<<OFF_W)-1:0][DATA_W-1:0]      latch_o
);
   localparam int PAGE_BYTES = 1 << OFF_W;
   localparam int PAGE_W     = ADDR_W - OFF_W;
   localparam int CNT_W      = $clog2(WIN_CYC + 1);

   generate
      if (WIN_CYC < 2) begin : g_bad_win
         $error("WIN_CYC must be at least 2");
      end
      if (PAGE_W < 1) begin : g_bad_addr
         $error("ADDR_W must exceed OFF_W");
      end
   endgenerate

   logic              open_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PAGE_W-1:0] page_q;
   logic [DATA_W-1:0] last_q;
   logic              accept;
   logic [OFF_W-1:0]  ld_off;

   assign accept  = ld_valid_i && !busy_i;
   assign ld_off  = ld_addr_i[OFF_W-1:0];
   assign start_o = open_q && !ld_valid_i && !busy_i && (cnt_q == CNT_W'(WIN_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
         page_q <= '0;
         last_q <= '0;
      end else if (accept) begin
         open_q <= 1'b1;
         cnt_q  <= '0;
         page_q <= ld_addr_i[ADDR_W-1:OFF_W];
         last_q <= ld_data_i;
      end else if (open_q && !busy_i) begin
         if (cnt_q == CNT_W'(WIN_CYC - 1)) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   generate
      for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mask_o[g]  <= 1'b0;
               latch_o[g] <= '1;
            end else if (clear_i) begin
               mask_o[g]  <= 1'b0;
            end else if (accept && ld_off == OFF_W'(g)) begin
               mask_o[g]  <= 1'b1;
               latch_o[g] <= ld_data_i;
            end
         end
      end
   endgenerate

   assign page_o      = page_q;
   assign last_data_o = last_q;

   // R8
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !clear_i) |=> $stable(mask_o));

   // R9
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(page_o));
endmodule

// File: rtl/ppseq_busy_timer.sv
module ppseq_busy_timer
   import ppseq_pkg::*;
#(
   parameter int OFF_W   = 6,
   parameter int CYC_CYC = 500000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             wr_en_o,
   output logic             wr_erase_o,
   output logic [OFF_W-1:0] wr_off_o
);
   localparam int PAGE_BYTES = 1 << OFF_W;
   localparam int CNT_W      = $clog2(CYC_CYC + 1);

   generate
      if (CYC_CYC < 2 * PAGE_BYTES + 1) begin : g_bad_cyc
         $error("CYC_CYC too short for erase and program passes");
      end
   endgenerate

   ppseq_phase_e     phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [OFF_W-1:0] off_q;
   logic             last_cyc;
   logic             last_off;

   assign last_cyc = (cnt_q == CNT_W'(CYC_CYC - 1));
   assign last_off = (off_q == OFF_W'(PAGE_BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         off_q   <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_ERASE;
                  cnt_q   <= '0;
                  off_q   <= '0;
               end
            end
            default: begin
               if (last_cyc) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
                  off_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
                  if (phase_q != PH_SETTLE) begin
                     off_q <= off_q + 1'b1;
                     if (last_off) begin
                        phase_q <= (phase_q == PH_ERASE) ? PH_PROG : PH_SETTLE;
                     end
                  end
               end
            end
         endcase
      end
   end

   assign busy_o     = (phase_q != PH_IDLE);
   assign done_o     = busy_o && last_cyc;
   assign wr_en_o    = (phase_q == PH_ERASE) || (phase_q == PH_PROG);
   assign wr_erase_o = (phase_q == PH_ERASE);
   assign wr_off_o   = off_q;

   // R4
   busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   // R4
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   // R5
   erase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (wr_erase_o && wr_off_o == '0));
endmodule

// File: rtl/ppseq_store.sv
module ppseq_store #(
   parameter int ADDR_W      = 15,
   parameter int DATA_W      = 8,
   parameter int OFF_W       = 6,
   parameter int STORE_PAGES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [ADDR_W-OFF_W-1:0]   wr_page_i,
   input  logic [OFF_W-1:0]          wr_off_i,
   input  logic [DATA_W-1:0]         wr_data_i,
   input  logic                      rd_en_i,
   input  logic [ADDR_W-1:0]         rd_addr_i,
   input  logic                      busy_i,
   input  logic                      start_i,
   input  logic [DATA_W-1:0]         last_data_i,
   output logic [DATA_W-1:0]         rd_data_o
);
   localparam int PAGE_W    = ADDR_W - OFF_W;
   localparam int SLOT_W    = (STORE_PAGES > 1) ? $clog2(STORE_PAGES) : 1;
   localparam int MEM_DEPTH = (1 << SLOT_W) << OFF_W;

   generate
      if (DATA_W < 3) begin : g_bad_data
         $error("DATA_W must be at least 3");
      end
      if ((STORE_PAGES & (STORE_PAGES - 1)) != 0) begin : g_bad_pages
         $error("STORE_PAGES must be a power of two");
      end
      if (SLOT_W > PAGE_W) begin : g_bad_slots
         $error("STORE_PAGES exceeds addressable pages");
      end
   endgenerate

   logic [SLOT_W-1:0] wr_slot;
   logic [SLOT_W-1:0] rd_slot;
   logic [PAGE_W-1:0] rd_page;
   logic              unused_page_bits;

   assign rd_page = rd_addr_i[ADDR_W-1:OFF_W];

   generate
      if (STORE_PAGES > 1) begin : g_multi
         assign wr_slot = wr_page_i[SLOT_W-1:0];
         assign rd_slot = rd_page[SLOT_W-1:0];
      end else begin : g_single
         assign wr_slot = '0;
         assign rd_slot = '0;
      end
   endgenerate

   assign unused_page_bits = ^{wr_page_i, rd_page};

   logic [DATA_W-1:0] mem_q [MEM_DEPTH];
   logic              tog_q;
   logic [DATA_W-1:0] status;

   assign status = {~last_data_i[DATA_W-1], tog_q, last_data_i[DATA_W-3:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_DEPTH; i++) begin
            mem_q[i] <= '1;
         end
      end else if (wr_en_i) begin
         mem_q[{wr_slot, wr_off_i}] <= wr_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tog_q     <= 1'b0;
         rd_data_o <= '0;
      end else begin
         if (start_i) begin
            tog_q <= 1'b0;
         end else if (rd_en_i && busy_i) begin
            tog_q <= ~tog_q;
         end
         if (rd_en_i) begin
            rd_data_o <= busy_i ? status : mem_q[{rd_slot, rd_addr_i[OFF_W-1:0]}];
         end
      end
   end

   // R6
   poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && busy_i) |=> (rd_data_o[DATA_W-1] != last_data_i[DATA_W-1]));

   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
   parameter int ADDR_W      = 15,
   parameter int DATA_W      = 8,
   parameter int OFF_W       = 6,
   parameter int WIN_CYC     = 7500,
   parameter int CYC_CYC     = 500000,
   parameter int STORE_PAGES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);
   localparam int PAGE_BYTES = 1 << OFF_W;
   localparam int PAGE_W     = ADDR_W - OFF_W;

   logic                               start;
   logic                               done;
   logic                               wr_en;
   logic                               wr_erase;
   logic [OFF_W-1:0]                   wr_off;
   logic [PAGE_W-1:0]                  page;
   logic [DATA_W-1:0]                  last_data;
   logic [PAGE_BYTES-1:0]              mask;
   logic [PAGE_BYTES-1:0][DATA_W-1:0]  latch;
   logic [DATA_W-1:0]                  wr_data;

   ppseq_load_window #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .OFF_W  (OFF_W),
      .WIN_CYC(WIN_CYC)
   ) i_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_valid_i (ld_valid),
      .ld_addr_i  (ld_addr),
      .ld_data_i  (ld_data),
      .busy_i     (busy),
      .clear_i    (done),
      .start_o    (start),
      .page_o     (page),
      .last_data_o(last_data),
      .mask_o     (mask),
      .latch_o    (latch)
   );

   ppseq_busy_timer #(
      .OFF_W  (OFF_W),
      .CYC_CYC(CYC_CYC)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .busy_o    (busy),
      .done_o    (done),
      .wr_en_o   (wr_en),
      .wr_erase_o(wr_erase),
      .wr_off_o  (wr_off)
   );

   assign wr_data = (wr_erase || !mask[wr_off]) ? '1 : latch[wr_off];

   ppseq_store #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .OFF_W      (OFF_W),
      .STORE_PAGES(STORE_PAGES)
   ) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en),
      .wr_page_i  (page),
      .wr_off_i   (wr_off),
      .wr_data_i  (wr_data),
      .rd_en_i    (rd_en),
      .rd_addr_i  (rd_addr),
      .busy_i     (busy),
      .start_i    (start),
      .last_data_i(last_data),
      .rd_data_o  (rd_data)
   );

   // R3
   quiet_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(ld_valid));

   // R8
   write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);
endmodule

// File: tb/test_page_prog_seq.sv
module test_page_prog_seq;
   localparam int WIN = 16;
   localparam int CYC = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0;
   logic [14:0] ld_addr = '0;
   logic [7:0]  ld_data = '0;
   logic        rd_en = 1'b0;
   logic [14:0] rd_addr = '0;
   logic [7:0]  rd_data;
   logic        busy;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   logic rd_seen = 1'b0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #10 clk = ~clk;

   page_prog_seq #(
      .WIN_CYC(WIN),
      .CYC_CYC(CYC),
      .STORE_PAGES(4)
   ) i_page_prog_seq (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .ld_data(ld_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      rd_seen <= rd_en && rst_n;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: compares each read result against the scoreboard
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            chk("scoreboard underflow", 1, 0);
         end else begin
            chk(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
         end
      end
   end

   task automatic do_load(input logic [14:0] a, input logic [7:0] d);
      @(posedge clk); #2;
      ld_valid = 1'b1; ld_addr = a; ld_data = d;
      @(posedge clk); #2;
      ld_valid = 1'b0;
   endtask

   task automatic do_read(input logic [14:0] a, input logic [7:0] e, input string tag);
      @(posedge clk); #2;
      rd_en = 1'b1; rd_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(posedge clk); #2;
      rd_en = 1'b0;
   endtask

   task automatic wait_busy(input logic lvl, output int at);
      forever begin
         @(posedge clk); #2;
         if (busy == lvl) break;
      end
      at = cyc;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int t_load, t_rise, t_fall;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      chk("R1 busy after reset", int'(busy), 0);
      do_read(15'h000, 8'hFF, "R1 erased page0");
      do_read(15'h0C5, 8'hFF, "R1 erased page3");

      // out-of-order loads into page 1 (R2)
      do_load(15'h045, 8'h3C);
      do_load(15'h040, 8'hA1);
      do_load(15'h07F, 8'h5E);
      t_load = cyc;
      wait_busy(1'b1, t_rise);
      chk("R3 window length", t_rise - t_load, WIN);
      repeat (3) @(posedge clk);
      do_read(15'h045, 8'h9E, "R6 R7 poll first");
      do_read(15'h000, 8'hDE, "R7 poll second");
      do_read(15'h07F, 8'h9E, "R7 poll third");
      do_load(15'h041, 8'h00);   // R8 ignored
      do_load(15'h083, 8'h44);   // R8 ignored
      wait_busy(1'b0, t_fall);
      chk("R4 busy length", t_fall - t_rise, CYC);
      do_read(15'h045, 8'h3C, "R2 byte 5");
      do_read(15'h040, 8'hA1, "R2 byte 0");
      do_read(15'h07F, 8'h5E, "R2 byte 63");
      do_read(15'h042, 8'hFF, "R5 unloaded byte");
      do_read(15'h041, 8'hFF, "R8 busy load page1");
      do_read(15'h083, 8'hFF, "R8 busy load page2");
      do_read(15'h000, 8'hFF, "R11 page0 untouched");
      repeat (3) @(posedge clk); #2;
      chk("R10 rd_data held", int'(rd_data), 8'hFF);

      // late load extends window; last load picks page (R9)
      do_load(15'h08A, 8'h12);
      repeat (WIN - 3) @(posedge clk);
      #2 chk("R3 window still open", int'(busy), 0);
      do_load(15'h040, 8'h77);
      t_load = cyc;
      wait_busy(1'b1, t_rise);
      chk("R3 extended window", t_rise - t_load, WIN);
      do_read(15'h040, 8'hB7, "R6 R7 new cycle poll");
      wait_busy(1'b0, t_fall);
      do_read(15'h040, 8'h77, "R2 reprogram byte 0");
      do_read(15'h04A, 8'h12, "R9 page of last load");
      do_read(15'h08A, 8'hFF, "R9 page2 untouched");
      do_read(15'h045, 8'hFF, "R5 old byte erased");
      do_read(15'h07F, 8'hFF, "R5 old byte 63 erased");
      do_read(15'h041, 8'hFF, "R8 no carry into next cycle");
      repeat (4) @(posedge clk);
      chk("scoreboard drained", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule